// File: doc/BRIEF.md
# Broadcast-Sample Convolver with Circulating Weights

This block computes a one-dimensional finite convolution over a stream of signed samples. For K signed weights w1..wK and a sample stream x1, x2, ..., result i is w1*x_i + w2*x_(i+1) + ... + wK*x_(i+K-1). The block is a linear array of K identical multiply-accumulate cells. Every accepted sample reaches all cells in the same cycle over one broadcast net. The weights circulate around a ring of registers and move one cell for each accepted sample. Each partial result stays in its own cell's wide accumulator until it is complete.

The host first streams one full set of K weights into the ring, w1 first. That set then keeps circulating, so a stream of any length needs no further weight traffic. A marker travels with w1 and another with wK. A cell that sees the w1 marker on an accepted sample starts a new sum. A cell that sees the wK marker completes its sum in that cycle. The selected sum is registered and presented with a one-cycle valid strobe. At most one sum completes per accepted sample, so results leave in index order, one for each accepted sample once the array has warmed up. Loading weights restarts this warm-up.

Top module: `conv_bcast_array`

## Requirements
- R1: Signed two's complement arithmetic throughout. After the accepting edge of sample x_(i+K-1) (counted from the last weight load), y_valid is high for exactly the next cycle and y_data equals w1*x_i + w2*x_(i+1) + ... + wK*x_(i+K-1).
- R2: After a weight load, the first K-1 accepted samples produce no output. From then on each accepted sample produces one result, so n accepted samples give exactly n+1-K results.
- R3: A cycle with w_valid high shifts w_data into the weight ring. K such cycles, in the order w1 first and wK last, define a weight set. The set recirculates and is reused for the whole stream, and every load cycle restarts the warm-up of R2.
- R4: In a cycle where w_valid and s_valid are both high, the sample is ignored. It does not enter any sum and produces no output, and the load itself produces no output.
- R5: Results are emitted in increasing index order. Samples accepted on consecutive cycles give results on consecutive cycles.
- R6: The accumulator width is AW = SW + WW + ceil(log2 K) by default. Sums of K extreme products, such as (-2^(SW-1))*(-2^(WW-1)) in every term, are exact.
- R7: Cycles with s_valid low leave every partial result unchanged and produce no output, so gaps in the sample stream do not change any result.
- R8: Reset, synchronous and active low, sets y_valid low and y_data to zero. Until a weight set has been loaded, samples produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Sample strobe; a sample is accepted when high and w_valid is low |
| s_data | input | SW | Signed sample broadcast to all cells |
| w_valid | input | 1 | Weight load strobe |
| w_data | input | WW | Signed weight, w1 first in each set |
| y_valid | output | 1 | One-cycle strobe marking a completed result |
| y_data | output | AW | Signed result, held between strobes |

## Verification
The assertions assume that weights always arrive in complete sets of K consecutive load cycles. Only then does exactly one cell carry each of the w1 and wK markers, so that a single finishing cell is guaranteed. The bench therefore loads weights only in full sets of four. A collision with a sample is placed inside such a set rather than cutting it short. Samples are fed only after a full set has been loaded, except for the directed case before the first load. In that case no marker is present yet, so none of the marker-based checks can be reached.

// File: rtl/conv_pkg.sv
// conv_pkg: shared width helpers for the broadcast-sample convolver.
// Assumes widths and tap counts are positive.
package conv_pkg;

    // Smallest accumulator that keeps a sum of k full products exact.
    function automatic int min_acc_width(input int sw, input int ww, input int k);
        return sw + ww + $clog2(k);
    endfunction

    // Width of a counter that must hold the value k.
    function automatic int count_width(input int k);
        return (k < 2) ? 1 : $clog2(k + 1);
    endfunction

endpackage

// File: rtl/conv_weight_ring.sv
// conv_weight_ring: a ring of K weight registers with two tag bits each.
// A load shifts a new weight in at cell 0. An accepted sample rotates the ring
// by one cell, from cell K-1 back to cell 0. The first tag rides with w1 and
// the last tag rides with wK. Assumes loads come in full sets of K.
module conv_weight_ring #(
    parameter int K  = 4,
    parameter int WW = 8,
    parameter int CW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [WW-1:0] w_in,
    input  logic                 step,
    output logic signed [WW-1:0] wt [K],
    output logic [K-1:0]         first_tag,
    output logic [K-1:0]         last_tag
);

    logic [CW-1:0] load_idx;
    logic          in_first;
    logic          in_last;

    // Position of the incoming weight inside its set.
    assign in_first = (load_idx == '0);
    assign in_last  = (load_idx == CW'(K - 1));

    // Count loads modulo K to tag the first and last weight of each set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_idx <= '0;
        end else if (load) begin
            load_idx <= in_last ? '0 : load_idx + 1'b1;
        end
    end

    // Shift on load, rotate on an accepted sample; the same path serves both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < K; c++) begin
                wt[c] <= '0;
            end
            first_tag <= '0;
            last_tag  <= '0;
        end else if (load || step) begin
            wt[0]        <= load ? w_in     : wt[K-1];
            first_tag[0] <= load ? in_first : first_tag[K-1];
            last_tag[0]  <= load ? in_last  : last_tag[K-1];
            for (int c = 1; c < K; c++) begin
                wt[c]        <= wt[c-1];
                first_tag[c] <= first_tag[c-1];
                last_tag[c]  <= last_tag[c-1];
            end
        end
    end

    // R3: rotation never creates or drops a start marker.
    p_start_marker_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ($countones(first_tag) == $past($countones(first_tag))));

    // R3: rotation never creates or drops a finish marker.
    p_finish_marker_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ($countones(last_tag) == $past($countones(last_tag))));

endmodule

// File: rtl/conv_mac_cell.sv
// conv_mac_cell: one multiply-accumulate cell holding one partial result.
// On an accepted sample it adds w*x to its sum. When the first tag is present
// it starts a new sum instead. The next sum value is exposed so that the
// unload stage can capture a sum completed in this cycle.
// Assumes AW >= SW + WW.
module conv_mac_cell #(
    parameter int SW = 8,
    parameter int WW = 8,
    parameter int AW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 first,
    input  logic signed [SW-1:0] x,
    input  logic signed [WW-1:0] w,
    output logic signed [AW-1:0] mac
);

    localparam int PW = SW + WW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] base;

    // Full-precision product of the broadcast sample and the local weight.
    assign prod = x * w;

    // Restart the sum on w1, otherwise extend the held sum.
    assign base = first ? '0 : acc;
    assign mac  = base + AW'(prod);

    // Keep the partial result; update only on an accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (step) begin
            acc <= mac;
        end
    end

    // R7: a partial result is untouched by cycles without an accepted sample.
    p_sum_held_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(acc));

endmodule

// File: rtl/conv_unload.sv
// conv_unload: picks the one cell whose sum completes in this cycle and
// registers it with a one-cycle strobe. A warm-up count suppresses sums
// begun before the latest weight load. Assumes full weight sets, which give
// at most one finishing cell.
module conv_unload #(
    parameter int K  = 4,
    parameter int AW = 18,
    parameter int CW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 load,
    input  logic [K-1:0]         last_tag,
    input  logic signed [AW-1:0] mac [K],
    output logic                 y_valid,
    output logic signed [AW-1:0] y_data
);

    logic [CW-1:0]        warm;
    logic                 warmed;
    logic signed [AW-1:0] pick;

    assign warmed = (warm == CW'(K - 1));

    // Count accepted samples after a load, saturating at K-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (load) begin
            warm <= '0;
        end else if (step && !warmed) begin
            warm <= warm + 1'b1;
        end
    end

    // AND-OR select of the finishing cell's sum.
    always_comb begin
        pick = '0;
        for (int c = 0; c < K; c++) begin
            if (last_tag[c]) begin
                pick = pick | mac[c];
            end
        end
    end

    // Register the completed result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_valid <= 1'b0;
            y_data  <= '0;
        end else begin
            y_valid <= step && warmed && (|last_tag);
            if (step && warmed && (|last_tag)) begin
                y_data <= pick;
            end
        end
    end

    // R5: no more than one cell finishes on any accepted sample.
    p_one_finisher_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && warmed) |-> $onehot0(last_tag));

endmodule

// File: rtl/conv_bcast_array.sv
// conv_bcast_array: K-cell convolver with broadcast samples, circulating
// weights and stationary sums. A sample is accepted when s_valid is high and
// w_valid is low. Assumes weights are loaded in complete sets of K, w1 first.
module conv_bcast_array #(
    parameter int K  = 4,
    parameter int SW = 8,
    parameter int WW = 8,
    parameter int AW = conv_pkg::min_acc_width(SW, WW, K)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    input  logic signed [SW-1:0] s_data,
    input  logic                 w_valid,
    input  logic signed [WW-1:0] w_data,
    output logic                 y_valid,
    output logic signed [AW-1:0] y_data
);

    localparam int CW = conv_pkg::count_width(K);

    logic                 step;
    logic signed [WW-1:0] wt [K];
    logic [K-1:0]         first_tag;
    logic [K-1:0]         last_tag;
    logic signed [AW-1:0] mac [K];

    // A load has priority; a colliding sample is dropped.
    assign step = s_valid && !w_valid;

    conv_weight_ring #(.K(K), .WW(WW), .CW(CW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (w_valid),
        .w_in      (w_data),
        .step      (step),
        .wt        (wt),
        .first_tag (first_tag),
        .last_tag  (last_tag)
    );

    for (genvar c = 0; c < K; c++) begin : g_cell
        conv_mac_cell #(.SW(SW), .WW(WW), .AW(AW)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step),
            .first (first_tag[c]),
            .x     (s_data),
            .w     (wt[c]),
            .mac   (mac[c])
        );
    end

    conv_unload #(.K(K), .AW(AW), .CW(CW)) u_unload (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (w_valid),
        .last_tag (last_tag),
        .mac      (mac),
        .y_valid  (y_valid),
        .y_data   (y_data)
    );

    // Checker: accepted samples since the last load, saturating at K.
    logic [CW-1:0] chk_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_seen <= '0;
        end else if (w_valid) begin
            chk_seen <= '0;
        end else if (s_valid && chk_seen != CW'(K)) begin
            chk_seen <= chk_seen + 1'b1;
        end
    end

    // R2: no result before K samples have followed a load.
    p_warmup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (chk_seen == CW'(K)));

    // R4: a load cycle never yields a result, even with a sample present.
    p_load_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |=> !y_valid);

    // R1: a result strobe follows an accepted sample.
    p_out_after_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_valid || w_valid) |=> !y_valid);

endmodule

// File: tb/tb_conv_bcast_array.sv
module tb_conv_bcast_array;

    localparam int K  = 4;
    localparam int SW = 8;
    localparam int WW = 8;
    localparam int AW = SW + WW + $clog2(K);
    localparam int NV = 12;

    // Stimulus vectors: samples walked by the main loop, and the first weight set.
    localparam int SAMP [NV] = '{5, -3, 7, 0, 127, -128, 12, -1, 64, -77, 2, 33};
    localparam int WSET [K]  = '{3, -2, 5, 1};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 s_valid = 1'b0;
    logic signed [SW-1:0] s_data = '0;
    logic                 w_valid = 1'b0;
    logic signed [WW-1:0] w_data = '0;
    logic                 y_valid;
    logic signed [AW-1:0] y_data;

    int n_chk = 0;
    int n_bad = 0;
    int hist [64];
    int hn = 0;
    int wts [K];
    int outs = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    conv_bcast_array #(.K(K), .SW(SW), .WW(WW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .w_valid(w_valid), .w_data(w_data), .y_valid(y_valid), .y_data(y_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, look just after the rising edge.
    task automatic cyc(input bit sv, input int sd, input bit wv, input int wd);
        @(negedge clk);
        s_valid = sv;
        s_data  = SW'(sd);
        w_valid = wv;
        w_data  = WW'(wd);
        @(posedge clk);
        #1;
    endtask

    // Load a full weight set; optionally collide a sample with the second load.
    task automatic load_set(input int w [K], input bit collide);
        for (int m = 0; m < K; m++) begin
            cyc(collide && m == 1, 99, 1'b1, w[m]);
            chk(y_valid == 1'b0, collide ? "R4" : "R3", int'(y_valid), 0);
            wts[m] = w[m];
        end
        hn = 0;
    endtask

    // Feed one sample and check the output against the convolution model.
    task automatic feed(input int x, input string req);
        int e;
        cyc(1'b1, x, 1'b0, 0);
        hist[hn] = x;
        hn++;
        if (hn >= K) begin
            e = 0;
            for (int m = 0; m < K; m++) begin
                e += wts[m] * hist[hn - K + m];
            end
            chk(y_valid == 1'b1, req, int'(y_valid), 1);
            chk(int'(y_data) == e, req, int'(y_data), e);
            outs++;
        end else begin
            chk(y_valid == 1'b0, "R2", int'(y_valid), 0);
        end
    endtask

    task automatic idle(input string req);
        cyc(1'b0, 0, 1'b0, 0);
        chk(y_valid == 1'b0, req, int'(y_valid), 0);
    endtask

    initial begin
        int wneg [K];
        int wmix [K];
        int w2 [K];
        w2   = '{-1, 4, 0, 7};
        wneg = '{-128, -128, -128, -128};
        wmix = '{127, 127, 127, 127};

        // R8: reset state.
        repeat (3) @(posedge clk);
        #1;
        chk(y_valid == 1'b0, "R8", int'(y_valid), 0);
        chk(int'(y_data) == 0, "R8", int'(y_data), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: samples before any weight load give nothing.
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 10 + i, 1'b0, 0);
            chk(y_valid == 1'b0, "R8", int'(y_valid), 0);
        end

        // R1, R2, R5: walk the vector table back to back.
        load_set(WSET, 1'b0);
        outs = 0;
        for (int i = 0; i < NV; i++) begin
            feed(SAMP[i], "R1");
        end
        chk(outs == NV + 1 - K, "R2", outs, NV + 1 - K);

        // R7: gaps between samples keep the stream intact.
        for (int i = 0; i < 5; i++) begin
            idle("R7");
            idle("R7");
            feed(i * 9 - 20, "R7");
        end

        // R3, R4: reload with a colliding sample, then a fresh warm-up.
        load_set(w2, 1'b1);
        for (int i = 0; i < 7; i++) begin
            feed(3 * i - 5, "R3");
        end
        idle("R5");

        // R6: extreme magnitudes.
        load_set(wneg, 1'b0);
        for (int i = 0; i < 6; i++) begin
            feed(-128, "R6");
        end
        load_set(wmix, 1'b0);
        for (int i = 0; i < 5; i++) begin
            feed(-128, "R6");
        end
        feed(127, "R6");

        // R5: mixed signs, consecutive outputs after the extremes.
        load_set(WSET, 1'b0);
        for (int i = 0; i < 8; i++) begin
            feed((i % 2 == 0) ? 127 - i : -128 + i, "R5");
        end
        idle("R7");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule